// File: doc/BRIEF.md
# Parallel NOR Flash Command and Status Emulator

A synthesizable behavioural stand-in for a small byte-wide parallel NOR flash. It is meant for test chips and prototyping boards. The bus is asynchronous in style: an active-low chip enable, an active-low output enable, an active-low write enable, an address and a byte of data. All of these are sampled on the system clock. The block qualifies write strobes, decodes the unlocked multi-write command sequences, and runs program and erase operations on an internal byte array. Each operation holds the part busy for a parameterised number of cycles.

While an operation runs, a read returns a progress byte instead of array data. Bit 7 is a polarity flag and bit 6 flips on every read. When the operation ends, reads return normal array data again. A supply-low input takes the place of analog voltage sensing and blocks every write.

The array holds `MEM_BYTES = 2**MEM_AW` bytes. Only the low `MEM_AW` address bits index it, so higher addresses alias onto it. Sectors are `2**SEC_AW` bytes, and a block is sixteen adjacent sectors. Reset fills the array with FFh. Command addresses are compared on `addr_i[14:0]`.

Top module: `flash_emu`

## Requirements
- R1: A bus write is accepted only under all of the following conditions: `ce_ni` and `we_ni` are both low for at least `GLITCH_CYC` clock samples; `oe_ni` is high on every one of those samples; `vlow_i` is low on every one of those samples. The address and data are taken from the last sample before the strobe ends. Shorter strobes and disqualified strobes are discarded.
- R2: Every command starts with an unlock pair: AAh written to 5555h, then 55h written to 2AAAh. The next write to 5555h picks the command: A0h program, 80h erase setup, 90h ID entry, F0h read mode. Any write that breaks the expected sequence returns the part to read-array mode and leaves ID mode.
- R3: After A0h, the next accepted write programs that byte to (old AND data). The part is busy for `T_PROG` cycles.
- R4: During a program, reads return bit 7 = complement of the written data bit 7, bit 6 = toggle, and bits 5..0 = 0. Afterwards reads return the stored byte.
- R5: During any erase, reads return bit 7 = 0, bit 6 = toggle, and bits 5..0 = 0. Afterwards erased bytes read FFh.
- R6: The sequence 80h, then AAh/5555h, then 55h/2AAAh, then 30h at an address erases only the sector holding that address. This takes `T_SEC` cycles.
- R7: The same setup followed by 50h at an address erases the sixteen-sector block holding that address. This takes `T_BLK` cycles. Other blocks are untouched.
- R8: The same setup followed by 10h at 5555h erases the whole array in `T_CHIP` cycles, six writes in all.
- R9: Writes that arrive while busy are ignored, with no effect on the array or on the command decoder.
- R10: In ID mode, reads at even addresses return 9Dh and reads at odd addresses return `DEV_ID`. Writing F0h returns the part to read-array mode.
- R11: The bit-6 toggle changes at the end of every read made while busy. It holds still within one read and while the part is idle. It is 0 after reset.
- R12: `data_oe_o` is high exactly while `ce_ni` is low, `oe_ni` is low and `we_ni` is high. After reset, every byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| vlow_i | input | 1 | Supply-low indicator, inhibits writes |
| addr_i | input | AW | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or status byte |
| data_oe_o | output | 1 | Read drive enable |

## Verification
An operation can finish while a read is in progress. In that case the same bus read sees both the end of the busy state and the switch from the status byte to array data. The bench provokes this by holding a single read low across the whole program interval and sampling the output on every cycle. The reference model requires the following order: the status byte first, carrying the model's toggle value, which must not change within the held read; then the programmed byte; and no return to status after that.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {
    DS_IDLE, DS_U1, DS_U2, DS_PGM, DS_E1, DS_E2, DS_E3
  } dec_st_e;

  typedef enum logic [1:0] {
    OP_PROG, OP_SEC, OP_BLK, OP_CHIP
  } op_e;

  localparam logic [14:0] UNLK_A1 = 15'h5555;
  localparam logic [14:0] UNLK_A2 = 15'h2AAA;
  localparam logic [7:0]  UNLK_D1 = 8'hAA;
  localparam logic [7:0]  UNLK_D2 = 8'h55;
  localparam logic [7:0]  CMD_PGM = 8'hA0;
  localparam logic [7:0]  CMD_ERS = 8'h80;
  localparam logic [7:0]  CMD_ID  = 8'h90;
  localparam logic [7:0]  CMD_RST = 8'hF0;
  localparam logic [7:0]  ERS_CHP = 8'h10;
  localparam logic [7:0]  ERS_SEC = 8'h30;
  localparam logic [7:0]  ERS_BLK = 8'h50;
  localparam logic [7:0]  MFR_ID  = 8'h9D;
endpackage

// File: rtl/flash_wr_filter.sv
module flash_wr_filter #(
  parameter int AW         = 15,
  parameter int GLITCH_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          vlow_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          wr_v_o,
  output logic [AW-1:0] wr_a_o,
  output logic [7:0]    wr_d_o
);
  localparam int CW = $clog2(GLITCH_CYC + 1) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          act, act_q, ok_q, wr_v_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] a_q;
  logic [7:0]    d_q;

  assign act = ~ce_ni & ~we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ok_q   <= 1'b0;
      cnt_q  <= '0;
      a_q    <= '0;
      d_q    <= '0;
      wr_v_q <= 1'b0;
    end else begin
      act_q  <= act;
      // strobe ends: commit only if long enough and never disqualified
      wr_v_q <= act_q & ~act & ok_q & (cnt_q >= CW'(GLITCH_CYC));
      if (act) begin
        a_q <= addr_i;
        d_q <= data_i;
        if (act_q) begin
          ok_q  <= ok_q & oe_ni & ~vlow_i;
          cnt_q <= (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
        end else begin
          ok_q  <= oe_ni & ~vlow_i;
          cnt_q <= CW'(1);
        end
      end
    end
  end

  assign wr_v_o = wr_v_q;
  assign wr_a_o = a_q;
  assign wr_d_o = d_q;
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_pkg::*;
#(
  parameter int AW     = 15,
  parameter int MEM_AW = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_v_i,
  input  logic [AW-1:0]     wr_a_i,
  input  logic [7:0]        wr_d_i,
  input  logic              busy_i,
  output logic              start_o,
  output op_e               op_o,
  output logic [MEM_AW-1:0] op_a_o,
  output logic [7:0]        op_d_o,
  output logic              id_o,
  output dec_st_e           st_o
);
  dec_st_e st_q, st_n;
  logic    id_q, id_n;
  logic    at_a1, at_a2, take;

  assign at_a1 = (wr_a_i[14:0] == UNLK_A1);
  assign at_a2 = (wr_a_i[14:0] == UNLK_A2);
  assign take  = wr_v_i & ~busy_i;

  always_comb begin
    st_n    = st_q;
    id_n    = id_q;
    start_o = 1'b0;
    op_o    = OP_PROG;
    if (take) begin
      st_n = DS_IDLE;
      id_n = 1'b0;
      unique case (st_q)
        DS_IDLE: if (at_a1 && wr_d_i == UNLK_D1) begin
          st_n = DS_U1;
          id_n = id_q;
        end
        DS_U1: if (at_a2 && wr_d_i == UNLK_D2) begin
          st_n = DS_U2;
          id_n = id_q;
        end
        DS_U2: if (at_a1) begin
          if (wr_d_i == CMD_PGM)     st_n = DS_PGM;
          else if (wr_d_i == CMD_ERS) st_n = DS_E1;
          else if (wr_d_i == CMD_ID)  id_n = 1'b1;
        end
        DS_PGM: start_o = 1'b1;
        DS_E1: if (at_a1 && wr_d_i == UNLK_D1) st_n = DS_E2;
        DS_E2: if (at_a2 && wr_d_i == UNLK_D2) st_n = DS_E3;
        DS_E3: begin
          if (at_a1 && wr_d_i == ERS_CHP) begin
            start_o = 1'b1;
            op_o    = OP_CHIP;
          end else if (wr_d_i == ERS_SEC) begin
            start_o = 1'b1;
            op_o    = OP_SEC;
          end else if (wr_d_i == ERS_BLK) begin
            start_o = 1'b1;
            op_o    = OP_BLK;
          end
        end
        default: st_n = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= DS_IDLE;
      id_q <= 1'b0;
    end else begin
      st_q <= st_n;
      id_q <= id_n;
    end
  end

  assign op_a_o = wr_a_i[MEM_AW-1:0];
  assign op_d_o = wr_d_i;
  assign id_o   = id_q;
  assign st_o   = st_q;
endmodule

// File: rtl/flash_core.sv
module flash_core
  import flash_pkg::*;
#(
  parameter int MEM_AW = 9,
  parameter int SEC_AW = 4,
  parameter int T_PROG = 8,
  parameter int T_SEC  = 20,
  parameter int T_BLK  = 30,
  parameter int T_CHIP = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [MEM_AW-1:0] op_a_i,
  input  logic [7:0]        op_d_i,
  input  logic [MEM_AW-1:0] rd_a_i,
  input  logic              rd_end_i,
  output logic              busy_o,
  output logic [7:0]        rd_d_o,
  output logic [7:0]        stat_o
);
  localparam int MEM_BYTES = 1 << MEM_AW;
  localparam int BLK_LSB   = SEC_AW + 4;
  localparam int TMAX1     = (T_PROG > T_SEC) ? T_PROG : T_SEC;
  localparam int TMAX2     = (T_BLK > T_CHIP) ? T_BLK : T_CHIP;
  localparam int TMAX      = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TW        = $clog2(TMAX + 1);

  logic [7:0]        mem_q [MEM_BYTES];
  logic              busy_q, tog_q;
  logic [TW-1:0]     tmr_q;
  op_e               op_q;
  logic [MEM_AW-1:0] a_q;
  logic [7:0]        d_q;
  logic              done;
  logic [TW-1:0]     t_load;

  assign done = busy_q & (tmr_q == '0);

  always_comb begin
    unique case (op_i)
      OP_PROG: t_load = TW'(T_PROG - 1);
      OP_SEC:  t_load = TW'(T_SEC - 1);
      OP_BLK:  t_load = TW'(T_BLK - 1);
      default: t_load = TW'(T_CHIP - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      op_q   <= OP_PROG;
      a_q    <= '0;
      d_q    <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (busy_q && rd_end_i) tog_q <= ~tog_q;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        tmr_q  <= t_load;
        op_q   <= op_i;
        a_q    <= op_a_i;
        d_q    <= op_d_i;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  // array changes only when the busy interval closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (done) begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        logic [MEM_AW-1:0] ia;
        ia = MEM_AW'(i);
        unique case (op_q)
          OP_PROG: if (ia == a_q) mem_q[i] <= mem_q[i] & d_q;
          OP_SEC:  if (ia[MEM_AW-1:SEC_AW] == a_q[MEM_AW-1:SEC_AW]) mem_q[i] <= 8'hFF;
          OP_BLK:  if (ia[MEM_AW-1:BLK_LSB] == a_q[MEM_AW-1:BLK_LSB]) mem_q[i] <= 8'hFF;
          default: mem_q[i] <= 8'hFF;
        endcase
      end
    end
  end

  assign busy_o = busy_q;
  assign rd_d_o = mem_q[rd_a_i];
  assign stat_o = {(op_q == OP_PROG) ? ~d_q[7] : 1'b0, tog_q, 6'b0};
endmodule

// File: rtl/flash_emu.sv
module flash_emu
  import flash_pkg::*;
#(
  parameter int         AW         = 15,
  parameter int         MEM_AW     = 9,
  parameter int         SEC_AW     = 4,
  parameter int         GLITCH_CYC = 2,
  parameter int         T_PROG     = 8,
  parameter int         T_SEC      = 20,
  parameter int         T_BLK      = 30,
  parameter int         T_CHIP     = 40,
  parameter logic [7:0] DEV_ID     = 8'h3E
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          vlow_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    data_o,
  output logic          data_oe_o
);
  logic              wr_v, start, busy, id_mode, rd_act, rd_prev_q;
  logic [AW-1:0]     wr_a;
  logic [7:0]        wr_d, op_d, arr_d, stat;
  logic [MEM_AW-1:0] op_a;
  op_e               op;
  dec_st_e           dec_st;

  flash_wr_filter #(.AW(AW), .GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .vlow_i, .addr_i, .data_i,
    .wr_v_o(wr_v), .wr_a_o(wr_a), .wr_d_o(wr_d)
  );

  flash_cmd_dec #(.AW(AW), .MEM_AW(MEM_AW)) u_dec (
    .clk_i, .rst_ni, .wr_v_i(wr_v), .wr_a_i(wr_a), .wr_d_i(wr_d),
    .busy_i(busy), .start_o(start), .op_o(op), .op_a_o(op_a),
    .op_d_o(op_d), .id_o(id_mode), .st_o(dec_st)
  );

  flash_core #(
    .MEM_AW(MEM_AW), .SEC_AW(SEC_AW), .T_PROG(T_PROG),
    .T_SEC(T_SEC), .T_BLK(T_BLK), .T_CHIP(T_CHIP)
  ) u_core (
    .clk_i, .rst_ni, .start_i(start), .op_i(op), .op_a_i(op_a),
    .op_d_i(op_d), .rd_a_i(addr_i[MEM_AW-1:0]), .rd_end_i(rd_prev_q & ~rd_act),
    .busy_o(busy), .rd_d_o(arr_d), .stat_o(stat)
  );

  assign rd_act = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_prev_q <= 1'b0;
    else         rd_prev_q <= rd_act;
  end

  always_comb begin
    if (busy)         data_o = stat;
    else if (id_mode) data_o = addr_i[0] ? DEV_ID : MFR_ID;
    else              data_o = arr_d;
  end

  assign data_oe_o = rd_act;
endmodule

// File: rtl/flash_emu_chk.sv
module flash_emu_chk
  import flash_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       oe_ni,
  input logic       we_ni,
  input logic       vlow_i,
  input logic       addr0_i,
  input logic [7:0] data_o,
  input logic       wr_v_i,
  input logic       busy_i,
  input logic       id_i,
  input dec_st_e    st_i
);
  logic rd;
  assign rd = ~ce_ni & ~oe_ni & we_ni;

  assert_vlow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vlow_i, 2) |-> !wr_v_i);

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(wr_v_i));

  assert_busy_status_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && rd |-> data_o[5:0] == 6'd0);

  assert_erase_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && wr_v_i |=> $stable(st_i) && $stable(id_i));

  assert_id_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_i && !busy_i && rd && !addr0_i |-> data_o == MFR_ID);
endmodule

bind flash_emu flash_emu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni),
  .we_ni(we_ni), .vlow_i(vlow_i), .addr0_i(addr_i[0]), .data_o(data_o),
  .wr_v_i(wr_v), .busy_i(busy), .id_i(id_mode), .st_i(dec_st)
);

// File: tb/flash_emu_test.sv
`timescale 1ns/1ps
module flash_emu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vlow = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;
  int          errs = 0, checks = 0, cyc = 0;
  bit          tog = 1'b0;

  always #2.5 clk = ~clk;

  flash_emu #(
    .T_PROG(8), .T_SEC(20), .T_BLK(30), .T_CHIP(80), .DEV_ID(8'h3E)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .vlow_i(vlow), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // per-clock drive enable model (R12)
  always @(posedge clk) begin
    #1;
    if (rst_n) chk("R12 oe", {7'd0, doe}, {7'd0, (!ce_n && !oe_n && we_n)});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog: got %0d expected <150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input int hold = 3,
                    input bit oe_low = 0, input bit vl = 0);
    @(negedge clk);
    addr = a; din = d; oe_n = ~oe_low; vlow = vl; ce_n = 0; we_n = 0;
    repeat (hold) @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1; vlow = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0;
    @(negedge clk);
    v = dout;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic unlock();
    wr(15'h5555, 8'hAA);
    wr(15'h2AAA, 8'h55);
  endtask

  task automatic prog(input logic [14:0] a, input logic [7:0] d);
    unlock(); wr(15'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [7:0] code, input logic [14:0] a);
    unlock(); wr(15'h5555, 8'h80); unlock(); wr(a, code);
  endtask

  // poll until data; model tracks toggle across status reads
  task automatic poll(input string req, input logic [14:0] a, input bit st7,
                      input logic [7:0] exp, input bit need_busy);
    logic [7:0] v;
    int n = 0;
    bit fin = 0;
    for (int k = 0; k < 100 && !fin; k++) begin
      rd(a, v);
      if (v === exp) fin = 1;
      else begin
        chk(req, v, {st7, tog, 6'd0});
        tog = ~tog;
        n++;
      end
    end
    chk(req, v, exp);
    if (need_busy) chk({req, " busy seen"}, {7'd0, n > 0}, 8'd1);
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    rd(15'h000, v); chk("R12 reset FF", v, 8'hFF);
    rd(15'h1FF, v); chk("R12 reset FF hi", v, 8'hFF);

    // R3 R4 program clears bits only
    prog(15'h040, 8'hF0); poll("R4 prog F0", 15'h040, 1'b0, 8'hF0, 1);
    prog(15'h040, 8'h3C); poll("R3 AND", 15'h040, 1'b1, 8'h30, 1);

    // R2 no unlock: command byte alone has no effect
    wr(15'h5555, 8'hA0); wr(15'h050, 8'h00);
    rd(15'h050, v); chk("R2 no unlock", v, 8'hFF);

    // R1 qualification: short strobe, OE low, supply low all discarded
    unlock(); wr(15'h5555, 8'hA0); wr(15'h060, 8'h00, 1);
    wr(15'h060, 8'h0F); poll("R1 glitch", 15'h060, 1'b1, 8'h0F, 1);
    unlock(); wr(15'h5555, 8'hA0); wr(15'h061, 8'h00, 3, 1);
    wr(15'h061, 8'hF3); poll("R1 oe low", 15'h061, 1'b0, 8'hF3, 1);
    unlock(); wr(15'h5555, 8'hA0); wr(15'h062, 8'h00, 3, 0, 1);
    wr(15'h062, 8'hCC); poll("R1 vlow", 15'h062, 1'b0, 8'hCC, 1);

    // R10 ID mode and exit
    unlock(); wr(15'h5555, 8'h90);
    rd(15'h000, v); chk("R10 mfr", v, 8'h9D);
    rd(15'h001, v); chk("R10 dev", v, 8'h3E);
    rd(15'h041, v); chk("R10 dev odd", v, 8'h3E);
    wr(15'h000, 8'hF0);
    rd(15'h040, v); chk("R10 exit", v, 8'h30);
    // R2 broken sequence leaves ID mode
    unlock(); wr(15'h5555, 8'h90);
    unlock(); wr(15'h5555, 8'h77);
    rd(15'h000, v); chk("R2 abort", v, 8'hFF);

    // R11 read held across completion: status stable then data
    prog(15'h070, 8'h5A);
    begin
      bit seen_st = 0, seen_d = 0;
      @(negedge clk);
      addr = 15'h070; ce_n = 0; oe_n = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (dout === 8'h5A) seen_d = 1;
        else if (seen_d) chk("R11 no return", dout, 8'h5A);
        else begin
          seen_st = 1;
          chk("R11 held status", dout, {1'b1, tog, 6'd0});
        end
      end
      ce_n = 1; oe_n = 1;
      chk("R11 both phases", {6'd0, seen_st, seen_d}, 8'd3);
    end
    rd(15'h070, v); chk("R11 idle", v, 8'h5A);

    // R6 sector erase
    prog(15'h020, 8'h12); poll("R3 p", 15'h020, 1'b1, 8'h12, 1);
    prog(15'h030, 8'h34); poll("R3 p", 15'h030, 1'b1, 8'h34, 1);
    erase(8'h30, 15'h025); poll("R5 sector", 15'h020, 1'b0, 8'hFF, 1);
    rd(15'h02F, v); chk("R6 in sector", v, 8'hFF);
    rd(15'h030, v); chk("R6 neighbour", v, 8'h34);

    // R7 block erase
    prog(15'h105, 8'h56); poll("R3 p", 15'h105, 1'b1, 8'h56, 1);
    prog(15'h010, 8'h78); poll("R3 p", 15'h010, 1'b1, 8'h78, 1);
    erase(8'h50, 15'h0F0); poll("R7 block", 15'h010, 1'b0, 8'hFF, 1);
    rd(15'h030, v); chk("R7 same block", v, 8'hFF);
    rd(15'h105, v); chk("R7 other block", v, 8'h56);

    // R8 chip erase with R9 lockout of a program sequence
    erase(8'h10, 15'h5555);
    prog(15'h003, 8'h00);
    poll("R8 chip", 15'h105, 1'b0, 8'hFF, 1);
    rd(15'h003, v); chk("R9 locked out", v, 8'hFF);
    rd(15'h040, v); chk("R8 all", v, 8'hFF);
    // R9 decoder untouched: fresh program still works
    prog(15'h003, 8'h81); poll("R9 after", 15'h003, 1'b0, 8'h81, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule